// File: doc/BRIEF.md
# Overlapping 1001 Serial Pattern Detector

This block watches a one-bit serial stream, taking one bit on every rising clock edge. It raises a match flag when the newest bits, in arrival order, read 1, 0, 0, 1. The flag is a Mealy output. It is a combinational function of the present state and the bit now on the input, so it goes high in the same cycle the closing 1 is presented, before that bit is clocked in.

After a match the machine does not return to its idle state. The closing 1 of one match counts as the opening 1 of the next, so overlapping occurrences are all reported. Internally the machine keeps two state bits with fixed codes: idle 00, seen "1" 01, seen "10" 10, seen "100" 11. Both the next-state logic and the flag follow fixed minimised sum-of-products equations. A synchronous active-low reset returns the machine to idle.

Top module: `seqdet_1001`

## Requirements
- R1: A clock edge with rst_n low puts the machine in idle (code 00), whatever bits came before. A pattern that reset interrupts is never completed by bits that arrive after reset.
- R2: match is 1 during a cycle exactly when, counting only bits taken since reset, the two preceding bits were 0, the bit before those was 1, and din is 1 in that cycle. The flag is combinational, so it appears in the same cycle as the closing 1.
- R3: Detection overlaps. The input 1001001 gives 0001001 on match, and 1001001001 gives 0001001001.
- R4: In every cycle where the condition of R2 does not hold, match is 0. This includes streams with no 1001 at all.
- R5: After a 1 is taken, the machine counts that 1 as the start of a pattern. Any run of several 1s followed by 0, 0, 1 therefore matches on the last 1.
- R6: After 1, 0, a further 1 abandons the partial pattern and starts a new one. The stream 1,0,1,0,0,1 matches only on its sixth bit.
- R7: match is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one serial bit per edge |
| rst_n | input | 1 | Synchronous active-low reset to idle |
| din | input | 1 | Serial data bit |
| match | output | 1 | High in the cycle that completes 1001 |

## Verification
The report of one match and the start of the next fall in the same cycle. The closing 1 raises the flag and is also taken as the opening bit of the following pattern. This is provoked with chained runs such as 1001001001, and with a sweep of every 10-bit stream after reset. Each cycle's flag is judged against a 4-bit history of the bits received since reset, so a missed restart shows up three cycles later as a missing match. A reset that arrives in the middle of a partial pattern is also exercised.

// File: rtl/seqdet_pkg.sv
// Package: shared state codes for the 1001 detector.
// Assumes: two state bits; the codes are fixed because the SOP
// next-state equations are written against them.
package seqdet_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'b00,  // nothing useful seen
        ST_ONE  = 2'b01,  // seen "1"
        ST_TEN  = 2'b10,  // seen "10"
        ST_HUND = 2'b11   // seen "100"
    } seq_state_t;
endpackage

// File: rtl/seqdet_next.sv
// Module: next-state logic of the detector, in minimised SOP form.
// Assumes: state codes from seqdet_pkg; purely combinational.
module seqdet_next
    import seqdet_pkg::*;
(
    input  seq_state_t cur,
    input  logic       bit_in,
    output seq_state_t nxt
);
    logic y1, y0, n1, n0;

    // Split the state into its two bits and form the SOP terms.
    always_comb begin
        y1  = cur[1];
        y0  = cur[0];
        n1  = (!y1 && !bit_in && y0) || (!bit_in && y1 && !y0);
        n0  = bit_in || (y1 && !y0);
        nxt = seq_state_t'({n1, n0});
    end
endmodule

// File: rtl/seqdet_state.sv
// Module: the two state flip-flops with synchronous active-low reset.
// Assumes: the D inputs come from seqdet_next.
module seqdet_state
    import seqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    input  seq_state_t d,
    output seq_state_t q
);
    // Capture the next state, or idle on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= ST_IDLE;
        else        q <= d;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (q == ST_IDLE));

    // R5
    one_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_in |=> (q == ST_ONE));

    // R6
    ten_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q == ST_TEN && !bit_in) |=> (q == ST_HUND));
endmodule

// File: rtl/seqdet_out.sv
// Module: Mealy output decode; the flag depends on state and live input.
// Assumes: state codes from seqdet_pkg.
module seqdet_out
    import seqdet_pkg::*;
(
    input  seq_state_t cur,
    input  logic       bit_in,
    output logic       hit
);
    // The flag is the single product term W.y1.y0.
    always_comb hit = bit_in && cur[1] && cur[0];
endmodule

// File: rtl/seqdet_1001.sv
// Module: top of the overlapping 1001 serial detector.
// Assumes: one bit per rising edge; synchronous active-low reset.
module seqdet_1001
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic match
);
    seq_state_t cur_st, nxt_st;

    seqdet_next u_next (.cur(cur_st), .bit_in(din), .nxt(nxt_st));

    seqdet_state u_state (
        .clk(clk), .rst_n(rst_n), .bit_in(din), .d(nxt_st), .q(cur_st)
    );

    seqdet_out u_out (.cur(cur_st), .bit_in(din), .hit(match));

    // R2
    match_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ($past(din, 3) && !$past(din, 2) && !$past(din, 1) && din));

    // R7
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
endmodule

// File: tb/sim_seqdet_1001.sv
module sim_seqdet_1001;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic match;

    int checks = 0;
    int errors = 0;
    logic [3:0] hist = '0;
    int valid = 0;
    logic [15:0] lfsr = 16'hACE1;

    seqdet_1001 u0 (.clk(clk), .rst_n(rst_n), .din(din), .match(match));

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: match=%b expected %b", tag, act, exp);
        end
    endtask

    // One reset cycle: the bench history is cleared alongside the design.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        hist = '0;
        valid = 0;
    endtask

    // Present one bit, check the Mealy flag before the edge, then clock it in.
    task automatic step(input logic b, input string tag, output logic got);
        logic exp;
        @(negedge clk);
        din = b;
        #1;
        exp = (valid >= 3) && ({hist[2:0], b} == 4'b1001);
        got = match;
        check(tag == "" ? (exp ? "R2" : "R4") : tag, match, exp);
        hist = {hist[2:0], b};
        if (valid < 4) valid++;
    endtask

    initial begin
        logic g;
        logic [9:0] out10;
        logic [6:0] out7;
        logic prev;

        do_reset();
        // R1: straight after reset, a 1 does not match.
        step(1'b1, "R1", g);

        // R1: reset cuts a partial 100, the next 1 does not complete it.
        step(1'b0, "", g);
        step(1'b0, "", g);
        do_reset();
        step(1'b1, "R1", g);

        // R3: chained overlaps.
        do_reset();
        for (int i = 6; i >= 0; i--) begin
            step(7'b1001001 >> i, "R3", g);
            out7[i] = g;
        end
        check("R3", out7 == 7'b0001001, 1'b1);
        do_reset();
        for (int i = 9; i >= 0; i--) begin
            step(10'b1001001001 >> i, "R3", g);
            out10[i] = g;
        end
        check("R3", out10 == 10'b0001001001, 1'b1);

        // R5: a run of 1s then 001.
        do_reset();
        for (int i = 6; i >= 0; i--) step(7'b1111001 >> i, "R5", g);
        check("R5", g, 1'b1);

        // R6: 101001 matches only at the end.
        do_reset();
        for (int i = 5; i >= 0; i--) step(6'b101001 >> i, "R6", g);
        check("R6", g, 1'b1);

        // Exhaustive sweep of every 10-bit stream after reset (R2, R4, R7).
        for (int s = 0; s < 1024; s++) begin
            do_reset();
            prev = 1'b0;
            for (int i = 9; i >= 0; i--) begin
                step(s[i], "", g);
                if (prev && g) check("R7", 1'b1, 1'b0);
                prev = g;
            end
        end

        // Long pseudo-random stream.
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], "", g);
        end

        finish_run();
    end
endmodule